// File: doc/BRIEF.md
# Port Edge Interrupt Unit

This block watches a small group of general-purpose port pins and raises an interrupt when a selected transition appears on one of them. A single polarity control chooses one sense for every pin at once: when set, falling edges are caught and the weak pull resistors act as pull-ups; when clear, rising edges are caught and the pull resistors act as pull-downs. A separate pull-enable control gates the resistors on all pins.

Each pin has a sticky request flag and a per-pin enable. Software reads and writes both through a narrow register port. A flag can only be cleared, by writing 0 to its bit. The unit ORs the enabled flags into one pending request, and a group enable then gates that request on its way to the CPU. Pins driven as outputs, and pins given over to analog use, never set a flag. Each pin input is synchronised through two flops, and the edge is taken from the synchronised current sample and the previous one.

Top module: `pin_edge_irq`

## Requirements
- R1: With `edge_pol` = 1, a high-to-low transition on an input pin sets that pin's flag, and a low-to-high transition leaves the flags unchanged.
- R2: With `edge_pol` = 0, a low-to-high transition on an input pin sets that pin's flag.
- R3: Each pin's edge sets only that pin's flag (bit i of the flag register is pin i), whatever level the other pins hold.
- R4: `irq_pend` is 1 exactly when some flag bit and the enable bit at the same position are both 1.
- R5: `irq_cpu` is 1 only when `irq_pend` is 1 and `grp_en` is 1.
- R6: A write with `reg_sel` = 1 (flag register) clears every flag bit written as 0 and leaves every bit written as 1 unchanged. A write with `reg_sel` = 0 loads the enable register. `reg_rdata` shows the register picked by `reg_sel`.
- R7: A pin with its `pin_dir` bit at 1 (output) or its `pin_analog` bit at 1 never sets its flag.
- R8: Asserting `rst_n` clears every enable bit and every flag bit at once.
- R9: `pull_up` bit i is `pull_en` AND `edge_pol` AND the pin is an input. `pull_dn` bit i is `pull_en` AND NOT `edge_pol` AND the pin is an input.
- R10: An edge that arrives in the same cycle as a write of 0 to its flag leaves that flag at 1.
- R11: A pin change made just after rising clock edge c shows in the flag read-back after rising edge c+3, and not after edge c+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_dir | input | NPIN | Pin direction, 1 = output |
| pin_analog | input | NPIN | 1 = pin used as analog input |
| edge_pol | input | 1 | 1 = falling edge with pull-up, 0 = rising edge with pull-down |
| pull_en | input | 1 | Global pull-resistor enable |
| grp_en | input | 1 | Group enable for the CPU request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata | input | NPIN | Write data |
| reg_rdata | output | NPIN | Read data of the selected register |
| pull_up | output | NPIN | Pull-up control per pin |
| pull_dn | output | NPIN | Pull-down control per pin |
| irq_pend | output | 1 | Some enabled flag is set |
| irq_cpu | output | 1 | Request to the CPU |

## Verification
A flag that sets on the wrong transition, on an output or analog pin, or in the wrong bit position shows in `reg_rdata` three clocks after the pin change, and in `irq_pend` in the same cycle when that bit is enabled. A flag that a write fails to clear, or that a simultaneous edge fails to keep, shows on the read-back the clock after the write. A wrong pull decode is visible at once, since the pull outputs follow their controls combinationally.

// File: rtl/pei_pkg.sv
package pei_pkg;
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAG   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pei_sync.sv
// Two-flop synchroniser per pin plus a previous-sample stage.
// samp_ok rises once all three stages hold post-reset samples.
module pei_sync #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_async,
  output logic [NPIN-1:0] cur,
  output logic [NPIN-1:0] prv,
  output logic            samp_ok
);
  localparam int WARM = 3;

  logic [NPIN-1:0] s1_q, s2_q, prv_q;
  logic [WARM-1:0] warm_q, warm_d;

  always_comb begin
    warm_d = {warm_q[WARM-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prv_q  <= '0;
      warm_q <= '0;
    end else begin
      s1_q   <= pin_async;
      s2_q   <= s1_q;
      prv_q  <= s2_q;
      warm_q <= warm_d;
    end
  end

  assign cur     = s2_q;
  assign prv     = prv_q;
  assign samp_ok = warm_q[WARM-1];
endmodule

// File: rtl/pei_edge.sv
// Per-pin qualified edge detect; the polarity is shared by all pins.
module pei_edge #(
  parameter int NPIN = 4
) (
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] prv,
  input  logic            samp_ok,
  input  logic            edge_pol,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPIN-1:0] pin_analog,
  output logic [NPIN-1:0] edge_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic fall, rise, raw, eligible;
    always_comb begin
      fall     = prv[i] & ~cur[i];
      rise     = cur[i] & ~prv[i];
      raw      = edge_pol ? fall : rise;
      eligible = ~pin_dir[i] & ~pin_analog[i];
      edge_o[i] = samp_ok & eligible & raw;
    end
  end
endmodule

// File: rtl/pei_regs.sv
// Enable and flag registers with the clear-by-zero write rule.
module pei_regs #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_flag,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] edge_i,
  output logic [NPIN-1:0] en_q,
  output logic [NPIN-1:0] flag_q
);
  logic [NPIN-1:0] en_d, flag_d, keep_mask;
  logic            en_ce;

  always_comb begin
    en_ce     = wr_en & ~wr_flag;
    en_d      = en_ce ? wdata : en_q;
    keep_mask = (wr_en & wr_flag) ? wdata : '1;
    flag_d    = (flag_q & keep_mask) | edge_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  // R6: a flag only drops after a flag write carrying 0 in that bit
  assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) & ~flag_q & ~(($past(wr_en) && $past(wr_flag)) ? ~$past(wdata) : '0)) == '0);

  // R1 R2: a flag only rises after a detected edge in that bit
  assert_set_by_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~$past(edge_i)) == '0);

  // R10: an edge always leaves its flag set, even against a clearing write
  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_i) & ~flag_q) == '0);

  // R6: enable register holds unless written through the enable select
  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(wr_en) && !$past(wr_flag)) |-> $stable(en_q));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pei_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPIN-1:0] pin_analog,
  input  logic            edge_pol,
  input  logic            pull_en,
  input  logic            grp_en,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  output logic [NPIN-1:0] pull_up,
  output logic [NPIN-1:0] pull_dn,
  output logic            irq_pend,
  output logic            irq_cpu
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_s_n;
  logic [NPIN-1:0]       cur, prv, edge_w, en_q, flag_q, in_mask;
  logic                  samp_ok;
  reg_sel_e              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RST_STAGES-1];

  pei_sync #(.NPIN(NPIN)) sync_i (
    .clk(clk), .rst_n(rst_s_n), .pin_async(pin_in),
    .cur(cur), .prv(prv), .samp_ok(samp_ok)
  );

  pei_edge #(.NPIN(NPIN)) edge_i (
    .cur(cur), .prv(prv), .samp_ok(samp_ok), .edge_pol(edge_pol),
    .pin_dir(pin_dir), .pin_analog(pin_analog), .edge_o(edge_w)
  );

  always_comb sel = reg_sel_e'(reg_sel);

  pei_regs #(.NPIN(NPIN)) regs_i (
    .clk(clk), .rst_n(rst_s_n), .wr_en(reg_wr), .wr_flag(sel == SEL_FLAG),
    .wdata(reg_wdata), .edge_i(edge_w), .en_q(en_q), .flag_q(flag_q)
  );

  always_comb begin
    reg_rdata = (sel == SEL_FLAG) ? flag_q : en_q;
    in_mask   = ~pin_dir;
    pull_up   = (pull_en &  edge_pol) ? in_mask : '0;
    pull_dn   = (pull_en & ~edge_pol) ? in_mask : '0;
    irq_pend  = |(flag_q & en_q);
    irq_cpu   = irq_pend & grp_en;
  end

  // R7: no flag rises on an output or analog pin
  assert_no_flag_excluded_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_q & ~$past(flag_q) & ($past(pin_dir) | $past(pin_analog))) == '0);

  // R9: pull-up and pull-down never both on, and never on an output
  assert_pull_legal_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((pull_up & pull_dn) == '0) && (((pull_up | pull_dn) & pin_dir) == '0));

  // R5: the CPU request needs the group enable
  assert_cpu_gated_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_cpu |-> (grp_en && (flag_q & en_q) != '0));
endmodule

// File: tb/pin_edge_irq_tb_top.sv
module pin_edge_irq_tb_top;
  localparam int NPIN = 4;
  localparam int K_RD = 0, K_PEND = 1, K_CPU = 2, K_PU = 3, K_PD = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NPIN-1:0] pin_in, pin_dir, pin_analog, reg_wdata;
  logic            edge_pol, pull_en, grp_en, reg_wr, reg_sel;
  logic [NPIN-1:0] reg_rdata, pull_up, pull_dn;
  logic            irq_pend, irq_cpu;

  typedef struct {
    int              due;
    int              kind;
    logic [NPIN-1:0] exp;
    string           req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_edge_irq #(.NPIN(NPIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .pin_analog(pin_analog), .edge_pol(edge_pol), .pull_en(pull_en),
    .grp_en(grp_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pull_up(pull_up),
    .pull_dn(pull_dn), .irq_pend(irq_pend), .irq_cpu(irq_cpu)
  );

  function automatic logic [NPIN-1:0] observe(int kind);
    case (kind)
      K_RD:    return reg_rdata;
      K_PEND:  return {{(NPIN-1){1'b0}}, irq_pend};
      K_CPU:   return {{(NPIN-1){1'b0}}, irq_cpu};
      K_PU:    return pull_up;
      default: return pull_dn;
    endcase
  endfunction

  // monitor: pops items that fall due and compares them
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [NPIN-1:0] act;
      it  = q.pop_front();
      act = observe(it.kind);
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d cyc=%0d actual=%b expected=%b",
                 it.req, it.kind, cyc, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int dly, int kind, logic [NPIN-1:0] exp, string req);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic sel, logic [NPIN-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_sel = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
  endtask

  initial begin
    rst_n = 1'b1; pin_in = '0; pin_dir = '0; pin_analog = '0;
    edge_pol = 1'b1; pull_en = 1'b0; grp_en = 1'b0;
    reg_wr = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
    #2 rst_n = 1'b0;
    step();
    // R8 reset state
    expect_at(0, K_RD, 4'b0000, "R8 flags after reset");
    expect_at(0, K_PEND, 4'b0000, "R8 pend after reset");
    drain();
    rst_n = 1'b1;
    idle(6);
    reg_sel = 1'b0; expect_at(0, K_RD, 4'b0000, "R8 enables after reset"); step(); reg_sel = 1'b1;

    // R9 pull control
    pull_en = 1'b1; pin_dir = 4'b0100; edge_pol = 1'b1;
    expect_at(0, K_PU, 4'b1011, "R9 pull-up");
    expect_at(0, K_PD, 4'b0000, "R9 no pull-down");
    step();
    edge_pol = 1'b0;
    expect_at(0, K_PD, 4'b1011, "R9 pull-down");
    expect_at(0, K_PU, 4'b0000, "R9 no pull-up");
    step();
    pull_en = 1'b0;
    expect_at(0, K_PD, 4'b0000, "R9 pulls off");
    step();
    pin_dir = '0; edge_pol = 1'b1;
    drain();

    // R1 rising ignored, falling caught; R11 latency
    pin_in = 4'b1111;
    idle(5);
    expect_at(0, K_RD, 4'b0000, "R1 rising ignored");
    step();
    pin_in = 4'b1110;
    expect_at(2, K_RD, 4'b0000, "R11 not yet at c+2");
    expect_at(3, K_RD, 4'b0001, "R11 R1 falling at c+3");
    drain();

    // R6 write 1 no effect, write 0 clears
    wr(1'b1, 4'b1111);
    expect_at(0, K_RD, 4'b0001, "R6 write 1 keeps");
    step();
    wr(1'b1, 4'b1110);
    expect_at(0, K_RD, 4'b0000, "R6 write 0 clears");
    drain();

    // R3 per-pin independence
    pin_in = 4'b1010;
    expect_at(3, K_RD, 4'b0100, "R3 pin2 only");
    drain();
    pin_in = 4'b0011;
    expect_at(3, K_RD, 4'b1100, "R3 pin3 adds, rising pins ignored");
    drain();

    // R4 R5 request generation
    wr(1'b0, 4'b0100);
    expect_at(0, K_PEND, 4'b0001, "R4 pend with enabled flag");
    expect_at(0, K_CPU, 4'b0000, "R5 cpu blocked by group");
    step();
    grp_en = 1'b1;
    expect_at(0, K_CPU, 4'b0001, "R5 cpu with group");
    step();
    wr(1'b0, 4'b0011);
    expect_at(0, K_PEND, 4'b0000, "R4 no pend when flags unenabled");
    expect_at(0, K_CPU, 4'b0000, "R5 cpu off");
    drain();
    grp_en = 1'b0;

    // R2 rising detection
    pin_in = 4'b0000;
    idle(5);
    wr(1'b1, 4'b0000);
    edge_pol = 1'b0;
    idle(2);
    pin_in = 4'b0101;
    expect_at(3, K_RD, 4'b0101, "R2 rising caught");
    drain();

    // R7 output and analog pins excluded
    pin_in = 4'b0000;
    idle(5);
    wr(1'b1, 4'b0000);
    pin_dir = 4'b0001; pin_analog = 4'b0010;
    idle(2);
    pin_in = 4'b1111;
    expect_at(3, K_RD, 4'b1100, "R7 excluded pins");
    drain();
    pin_dir = '0; pin_analog = '0;

    // R10 edge coincident with clearing write
    pin_in = 4'b0000;
    idle(5);
    wr(1'b1, 4'b0000);
    pin_in = 4'b0010;
    idle(5);
    expect_at(0, K_RD, 4'b0010, "R10 setup");
    step();
    pin_in = 4'b0011;
    idle(2);
    wr(1'b1, 4'b0000);
    expect_at(0, K_RD, 4'b0001, "R10 edge wins over clear");
    drain();

    // R8 reset mid-run
    wr(1'b0, 4'b1111);
    rst_n = 1'b0;
    expect_at(0, K_RD, 4'b0000, "R8 flags cleared");
    expect_at(0, K_PEND, 4'b0000, "R8 pend cleared");
    drain();
    reg_sel = 1'b0;
    expect_at(0, K_RD, 4'b0000, "R8 enables cleared");
    drain();
    rst_n = 1'b1;
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule